// File: doc/BRIEF.md
# Receiver Wakeup and Idle Detector

This block sits beside the bit-sampling stage of an asynchronous serial receiver. It decides when a receiver that software has put to sleep should resume delivering characters. Each sampled bit arrives with a strobe. Flags on that strobe mark the start bit and the stop bit. When the stop bit arrives, the finished character is presented with it. The block counts runs of 1s to find idle characters. It also watches the top bit of each finished character for an address mark.

A small control register selects the wake condition: idle line or address mark. It also selects where the idle count may begin (after the start bit or after the stop bit) and the character length (8 or 9 data bits). While the receiver sleeps, finished characters are withheld. The selected wake condition clears the sleep flag and emits a one-cycle wake pulse. In address-mark mode, the character that carries the mark is the first one delivered.

Top module: `rx_wake_detect`

## Requirements
- R1: After reset, `asleep`, `wake_pulse`, `idle_det` and `char_vld` are 0. All three controls read back as 0: idle-line wakeup, counting from the start bit, 8-bit characters.
- R2: When `ctl_we` is high at a clock edge, the three control inputs are stored. `ctl_addr_wake` selects idle-line wakeup at 0 and address-mark wakeup at 1. `ctl_idle_after_stop` selects counting from the start bit at 0 and from the stop bit at 1. `ctl_nine_bit` selects 8 data bits at 0 and 9 at 1.
- R3: An idle character is a run of consecutive strobed 1s, 10 long with 8 data bits and 11 long with 9. A strobed 0 restarts the run. `idle_det` pulses for one cycle, in the cycle after the strobe that completes the run, and only once per run.
- R4: With counting from the start bit, data 1s and the stop bit count toward the run. An all-ones character followed by a single idle bit therefore reports an idle character.
- R5: With counting from the stop bit, nothing is counted from the start-bit strobe through the stop-bit strobe. Counting starts at 0 on the strobe after the stop bit, so the all-ones case of R4 reports nothing.
- R6: A high `sleep_req` sets `asleep` in the next cycle.
- R7: In idle-line mode, a sleeping block that completes an idle character clears `asleep`. It raises `wake_pulse` for one cycle, in the same cycle as `idle_det`.
- R8: In address-mark mode, a sleeping block wakes on a finished character whose MSB is 1. The MSB is `rx_char` bit 7 with 8 data bits and bit 8 with 9 data bits. Bit 8 is ignored in 8-bit mode.
- R9: While `asleep` is 1, a finished character that does not wake the block produces no `char_vld`.
- R10: A finished character is delivered the cycle after its stop-bit strobe, with `char_vld` = 1 and `char_q` = `rx_char`. This includes the address-mark character that wakes the block.
- R11: The unselected condition never wakes the block. Idle runs are ignored in address-mark mode, and marked characters are ignored in idle-line mode.
- R12: `sleep_req` takes precedence. If a wake condition occurs in the same cycle, there is no wake pulse and `asleep` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Store the three control inputs |
| ctl_addr_wake | input | 1 | 0 idle-line wakeup, 1 address-mark wakeup |
| ctl_idle_after_stop | input | 1 | 0 count from start bit, 1 count from stop bit |
| ctl_nine_bit | input | 1 | 0 eight data bits, 1 nine data bits |
| bit_stb | input | 1 | One sampled bit is valid |
| bit_val | input | 1 | Sampled line value |
| start_det | input | 1 | This strobe is a start bit |
| char_done | input | 1 | This strobe is a stop bit; character finished |
| rx_char | input | DATA_BITS+1 | Finished character, valid with `char_done` |
| sleep_req | input | 1 | Software request to sleep |
| asleep | output | 1 | Receiver is sleeping |
| wake_pulse | output | 1 | One-cycle pulse on wakeup |
| idle_det | output | 1 | One-cycle pulse on an idle character |
| char_vld | output | 1 | A character is delivered |
| char_q | output | DATA_BITS+1 | Delivered character |

## Verification
The run counter has an off-by-one hazard. A counter that is one step off, or that counts the stop bit in the wrong mode, moves `idle_det` by a whole strobe. That shift shows within one bit time of the run's end, in the false-idle and 9-bit scenarios. A wrong MSB choice or a stale sleep flag shows within one cycle of the stop-bit strobe: a missing or extra `wake_pulse`, or a `char_vld` that should not be there. A reference model compares every output on every cycle, so a wrong state is reported the cycle it reaches a port.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic {
        WAKE_ON_IDLE = 1'b0,
        WAKE_ON_MARK = 1'b1
    } wake_mode_e;

    typedef struct packed {
        wake_mode_e mode;
        logic       count_from_stop;
        logic       nine_bit;
    } rxw_cfg_t;

    localparam rxw_cfg_t CFG_RESET = '{mode: WAKE_ON_IDLE, count_from_stop: 1'b0, nine_bit: 1'b0};

    // Bits in one frame: start + data + stop (+1 for the ninth data bit).
    function automatic int unsigned frame_bits(int unsigned data_bits, logic nine);
        return data_bits + 2 + (nine ? 1 : 0);
    endfunction

endpackage

// File: rtl/rxw_idle_cnt.sv
module rxw_idle_cnt #(
    parameter int unsigned DATA_BITS = 8,
    localparam int unsigned CW = $clog2(DATA_BITS + 4)
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic val,
    input  logic is_start,
    input  logic is_stop,
    input  logic from_stop,
    input  logic nine_bit,
    output logic hit,
    output logic idle_q
);
    import rxw_pkg::*;

    logic [CW-1:0] run_cnt;
    logic          armed;
    logic [CW-1:0] run_len;
    logic          frame_edge;
    logic          counting;

    assign run_len    = CW'(frame_bits(DATA_BITS, nine_bit));
    assign frame_edge = from_stop && (is_start || is_stop);
    assign counting   = armed || !from_stop;
    assign hit        = stb && val && !frame_edge && counting && (run_cnt == run_len - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            armed   <= 1'b1;
            idle_q  <= 1'b0;
        end else begin
            idle_q <= hit;
            if (stb) begin
                if (from_stop && is_start) begin
                    armed   <= 1'b0;
                    run_cnt <= '0;
                end else if (from_stop && is_stop) begin
                    armed   <= 1'b1;
                    run_cnt <= '0;
                end else if (!val) begin
                    run_cnt <= '0;
                end else if (counting && run_cnt < run_len) begin
                    run_cnt <= run_cnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/rxw_wake_ctrl.sv
module rxw_wake_ctrl #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rxw_pkg::rxw_cfg_t    cfg,
    input  logic                 idle_hit,
    input  logic                 chr_end,
    input  logic [DATA_BITS:0]   chr,
    input  logic                 sleep_req,
    output logic                 asleep,
    output logic                 wake_pulse,
    output logic                 chr_vld,
    output logic [DATA_BITS:0]   chr_q
);
    import rxw_pkg::*;

    logic mark;
    logic cond;
    logic wake_now;
    logic pass;

    assign mark     = cfg.nine_bit ? chr[DATA_BITS] : chr[DATA_BITS-1];
    assign cond     = (cfg.mode == WAKE_ON_MARK) ? (chr_end && mark) : idle_hit;
    assign wake_now = asleep && cond && !sleep_req;
    assign pass     = chr_end && (!asleep || wake_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep     <= 1'b0;
            wake_pulse <= 1'b0;
            chr_vld    <= 1'b0;
            chr_q      <= '0;
        end else begin
            wake_pulse <= wake_now;
            chr_vld    <= pass;
            if (pass) chr_q <= chr;
            if (sleep_req)     asleep <= 1'b1;
            else if (wake_now) asleep <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_wake_detect.sv
module rx_wake_detect #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_we,
    input  logic                 ctl_addr_wake,
    input  logic                 ctl_idle_after_stop,
    input  logic                 ctl_nine_bit,
    input  logic                 bit_stb,
    input  logic                 bit_val,
    input  logic                 start_det,
    input  logic                 char_done,
    input  logic [DATA_BITS:0]   rx_char,
    input  logic                 sleep_req,
    output logic                 asleep,
    output logic                 wake_pulse,
    output logic                 idle_det,
    output logic                 char_vld,
    output logic [DATA_BITS:0]   char_q
);
    import rxw_pkg::*;

    rxw_cfg_t cfg_q;
    logic     is_start;
    logic     is_stop;
    logic     idle_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (ctl_we) begin
            cfg_q.mode            <= wake_mode_e'(ctl_addr_wake);
            cfg_q.count_from_stop <= ctl_idle_after_stop;
            cfg_q.nine_bit        <= ctl_nine_bit;
        end
    end

    assign is_start = bit_stb && start_det;
    assign is_stop  = bit_stb && char_done;

    rxw_idle_cnt #(.DATA_BITS(DATA_BITS)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .stb      (bit_stb),
        .val      (bit_val),
        .is_start (is_start),
        .is_stop  (is_stop),
        .from_stop(cfg_q.count_from_stop),
        .nine_bit (cfg_q.nine_bit),
        .hit      (idle_hit),
        .idle_q   (idle_det)
    );

    rxw_wake_ctrl #(.DATA_BITS(DATA_BITS)) u_wake (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_q),
        .idle_hit  (idle_hit),
        .chr_end   (is_stop),
        .chr       (rx_char),
        .sleep_req (sleep_req),
        .asleep    (asleep),
        .wake_pulse(wake_pulse),
        .chr_vld   (char_vld),
        .chr_q     (char_q)
    );
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker (
    input logic clk,
    input logic rst,
    input logic bit_stb,
    input logic bit_val,
    input logic char_done,
    input logic sleep_req,
    input logic asleep,
    input logic wake_pulse,
    input logic idle_det,
    input logic char_vld
);
    // R6
    sleep_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> $past(sleep_req));
    // R7
    sleep_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(asleep) |-> wake_pulse);
    // R12
    wake_origin_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> ($past(asleep) && !$past(sleep_req)));
    // R3
    idle_source_chk: assert property (@(posedge clk) disable iff (rst)
        idle_det |-> ($past(bit_stb) && $past(bit_val)));
    // R3
    idle_once_chk: assert property (@(posedge clk) disable iff (rst)
        idle_det |=> !idle_det);
    // R10
    deliver_source_chk: assert property (@(posedge clk) disable iff (rst)
        char_vld |-> ($past(char_done) && $past(bit_stb)));
endmodule

bind rx_wake_detect rxw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .char_done (char_done),
    .sleep_req (sleep_req),
    .asleep    (asleep),
    .wake_pulse(wake_pulse),
    .idle_det  (idle_det),
    .char_vld  (char_vld)
);

// File: tb/rx_wake_detect_tb.sv
module rx_wake_detect_tb;
    localparam int CLK_P = 10;
    localparam int DB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_we = 0, ctl_addr_wake = 0, ctl_idle_after_stop = 0, ctl_nine_bit = 0;
    logic bit_stb = 0, bit_val = 1, start_det = 0, char_done = 0, sleep_req = 0;
    logic [DB:0] rx_char = '0;
    logic asleep, wake_pulse, idle_det, char_vld;
    logic [DB:0] char_q;

    int errors = 0, checks = 0;
    int idle_seen = 0, wake_seen = 0, vld_seen = 0;
    logic [DB:0] last_char = '0;
    bit finished = 0;

    // reference model state
    int m_cnt; bit m_arm, m_sleep, m_wake, m_idle, m_vld;
    bit m_addr, m_stop, m_nine;
    logic [DB:0] m_char;

    always #(CLK_P/2) clk = ~clk;

    rx_wake_detect #(.DATA_BITS(DB)) u_dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_addr_wake(ctl_addr_wake),
        .ctl_idle_after_stop(ctl_idle_after_stop), .ctl_nine_bit(ctl_nine_bit),
        .bit_stb(bit_stb), .bit_val(bit_val), .start_det(start_det), .char_done(char_done),
        .rx_char(rx_char), .sleep_req(sleep_req), .asleep(asleep), .wake_pulse(wake_pulse),
        .idle_det(idle_det), .char_vld(char_vld), .char_q(char_q));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_arm = 1; m_sleep = 0; m_wake = 0; m_idle = 0; m_vld = 0;
            m_addr = 0; m_stop = 0; m_nine = 0; m_char = '0;
        end else begin
            int flen; bit hit, msb, wk;
            flen = DB + 2 + (m_nine ? 1 : 0);
            hit = 0;
            if (bit_stb) begin
                if (m_stop && start_det) begin m_arm = 0; m_cnt = 0; end
                else if (m_stop && char_done) begin m_arm = 1; m_cnt = 0; end
                else if (!bit_val) m_cnt = 0;
                else if ((m_arm || !m_stop) && m_cnt < flen) begin
                    m_cnt++;
                    hit = (m_cnt == flen);
                end
            end
            msb = m_nine ? rx_char[DB] : rx_char[DB-1];
            wk = m_sleep && !sleep_req && (m_addr ? (bit_stb && char_done && msb) : hit);
            m_vld = bit_stb && char_done && (!m_sleep || wk);
            if (m_vld) m_char = rx_char;
            m_wake = wk; m_idle = hit;
            if (sleep_req) m_sleep = 1; else if (wk) m_sleep = 0;
            if (ctl_we) begin m_addr = ctl_addr_wake; m_stop = ctl_idle_after_stop; m_nine = ctl_nine_bit; end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(asleep == m_sleep, "R6 asleep", asleep, m_sleep);
            chk(wake_pulse == m_wake, "R7 wake_pulse", wake_pulse, m_wake);
            chk(idle_det == m_idle, "R3 idle_det", idle_det, m_idle);
            chk(char_vld == m_vld, "R9 char_vld", char_vld, m_vld);
            if (m_vld) chk(char_q == m_char, "R10 char_q", char_q, m_char);
            if (idle_det) idle_seen++;
            if (wake_pulse) wake_seen++;
            if (char_vld) begin vld_seen++; last_char = char_q; end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic drive_bit(input bit v, input bit sd, input bit cd, input logic [DB:0] c, input bit slp);
        bit_stb = 1; bit_val = v; start_det = sd; char_done = cd; rx_char = c; sleep_req = slp;
        cyc();
        bit_stb = 0; start_det = 0; char_done = 0; sleep_req = 0; bit_val = 1;
        cyc();
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) drive_bit(1, 0, 0, '0, 0);
    endtask

    task automatic send(input logic [DB:0] c, input bit nine);
        drive_bit(0, 1, 0, '0, 0);
        for (int i = 0; i < (nine ? DB + 1 : DB); i++) drive_bit(c[i], 0, 0, '0, 0);
        drive_bit(1, 0, 1, c, 0);
    endtask

    task automatic set_cfg(input bit a, input bit s, input bit n);
        ctl_we = 1; ctl_addr_wake = a; ctl_idle_after_stop = s; ctl_nine_bit = n;
        cyc();
        ctl_we = 0;
    endtask

    task automatic go_sleep();
        sleep_req = 1; cyc(); sleep_req = 0; cyc();
    endtask

    task automatic settle();
        cyc(); cyc();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int i0, w0, v0;
        repeat (3) cyc();
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(asleep == 0 && wake_pulse == 0 && idle_det == 0 && char_vld == 0, "R1 outputs", asleep, 0);
        cyc();

        // R3 idle run of 10 in 8-bit mode, once per run
        drive_bit(0, 0, 0, '0, 0);
        i0 = idle_seen; idle_bits(9); settle();
        chk(idle_seen == i0, "R3 nine ones", idle_seen - i0, 0);
        idle_bits(1); settle();
        chk(idle_seen == i0 + 1, "R3 tenth one", idle_seen - i0, 1);
        idle_bits(6); settle();
        chk(idle_seen == i0 + 1, "R3 once per run", idle_seen - i0, 1);

        // R4 false idle when counting from start bit
        i0 = idle_seen; send(9'h0FF, 0); idle_bits(1); settle();
        chk(idle_seen == i0 + 1, "R4 false idle", idle_seen - i0, 1);

        // R5 counting from stop bit
        set_cfg(0, 1, 0);
        i0 = idle_seen; send(9'h0FF, 0); idle_bits(9); settle();
        chk(idle_seen == i0, "R5 no false idle", idle_seen - i0, 0);
        idle_bits(1); settle();
        chk(idle_seen == i0 + 1, "R5 full idle after stop", idle_seen - i0, 1);

        // R2 R8 address-mark wakeup, 8-bit
        set_cfg(1, 0, 0);
        go_sleep();
        chk(asleep == 1, "R6 sleep set", asleep, 1);
        w0 = wake_seen; v0 = vld_seen;
        send(9'h055, 0); settle();
        chk(vld_seen == v0 && asleep == 1, "R9 suppressed", vld_seen - v0, 0);
        send(9'h100, 0); settle();
        chk(wake_seen == w0 && asleep == 1, "R8 bit8 ignored in 8-bit", wake_seen - w0, 0);
        idle_bits(12); settle();
        chk(wake_seen == w0, "R11 idle ignored in mark mode", wake_seen - w0, 0);
        send(9'h0A5, 0); settle();
        chk(wake_seen == w0 + 1 && asleep == 0, "R8 mark wakes", wake_seen - w0, 1);
        chk(vld_seen == v0 + 1 && last_char == 9'h0A5, "R10 mark char delivered", last_char, 9'h0A5);

        // R8 nine-bit MSB
        set_cfg(1, 0, 1);
        go_sleep();
        w0 = wake_seen;
        send(9'h0FF, 1); settle();
        chk(wake_seen == w0 && asleep == 1, "R8 bit7 ignored in 9-bit", wake_seen - w0, 0);
        send(9'h101, 1); settle();
        chk(wake_seen == w0 + 1 && last_char == 9'h101, "R8 bit8 mark wakes", last_char, 9'h101);

        // R7 R3 idle wake, 9-bit run length 11
        set_cfg(0, 0, 1);
        go_sleep();
        w0 = wake_seen;
        drive_bit(0, 0, 0, '0, 0);
        idle_bits(10); settle();
        chk(wake_seen == w0 && asleep == 1, "R3 ten ones in 9-bit", wake_seen - w0, 0);
        idle_bits(1); settle();
        chk(wake_seen == w0 + 1 && asleep == 0, "R7 idle wake", wake_seen - w0, 1);

        // R11 mark ignored in idle mode
        set_cfg(0, 0, 0);
        go_sleep();
        w0 = wake_seen; v0 = vld_seen;
        send(9'h080, 0); settle();
        chk(wake_seen == w0 && vld_seen == v0 && asleep == 1, "R11 mark ignored", wake_seen - w0, 0);

        // R12 sleep_req beats wake
        drive_bit(0, 0, 0, '0, 0);
        idle_bits(9);
        drive_bit(1, 0, 0, '0, 1); settle();
        chk(wake_seen == w0 && asleep == 1, "R12 sleep wins", asleep, 1);

        // R1 R2 controls cleared by reset: idle wake, start-bit counting
        rst = 1; cyc(); cyc(); rst = 0; cyc();
        go_sleep();
        w0 = wake_seen;
        send(9'h080, 0); settle();
        chk(asleep == 1, "R1 mark mode cleared", asleep, 1);
        send(9'h0FF, 0); idle_bits(1); settle();
        chk(wake_seen == w0 + 1 && asleep == 0, "R1 count-type cleared", wake_seen - w0, 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule